// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the serial slave end of a two-wire configuration bus. It samples the clock and data lines against the system clock, recognises start and stop conditions, and compares the incoming 7-bit device address with its own. One bit of that address is taken from a strap pin, so two copies of the block can share a bus. When it is addressed, it acknowledges by pulling the data line low. It then gives access to a bank of 8-bit registers that sits outside the block.

A write transfer sends an address byte, then a subaddress byte that loads an internal pointer, then any number of data bytes. A read transfer returns bytes starting at the current pointer, which is usually set by a short write followed by a repeated start. Every byte moves the pointer to the next register. At the top of the range, reads keep returning the highest register. A write at that point is refused and ends the transfer.

The register bank is reached through a strobe, address and data port with a combinational read-data return. The data line is only ever pulled low (`sda_oe` = 1) or released.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and `reg_we` is low.
- R2: The first byte after a start carries the address in its upper seven bits, MSB first, and the direction in bit 0 (1 = read, 0 = write). The block answers only when the address equals `DEV_ADDR` with bit 1 replaced by `addr_strap`. Any other address gets no acknowledge, and the block ignores the bus until the next start.
- R3: An accepted address, subaddress or write-data byte is acknowledged by holding SDA low through the ninth SCL pulse.
- R4: The second byte of a write is the subaddress. If bit 7 is 1, or the value is not below `NREGS`, it gets no acknowledge, the block goes idle, and later data bytes are neither acknowledged nor stored.
- R5: Each write-data byte is stored with a single-cycle `reg_we` pulse at the current pointer, and the pointer then advances by one.
- R6: A write-data byte that arrives after the highest register (`NREGS`-1) has been written is not stored and gets no acknowledge, and the block goes idle.
- R7: Read data comes out MSB first, starting at the pointer. SDA changes only while SCL is low, and the pointer advances after each byte.
- R8: Once the highest register has been read, further read bytes repeat its contents. A master NACK ends the read and releases SDA.
- R9: A stop condition at any point returns the block to idle. A start at any point abandons the current transfer and begins a new address phase. A byte cut short in this way is not stored.
- R10: The pointer keeps its value across a repeated start. A read after a subaddress-only write therefore begins at that subaddress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| addr_strap | input | 1 | Value used for address bit 1 |
| reg_we | output | 1 | One-cycle write strobe to the register bank |
| reg_addr | output | AW | Register index, equal to the current pointer |
| reg_wdata | output | 8 | Byte to be written |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
A wrong internal state shows up at the ports within one byte time. A bad address or subaddress decision is visible as a missing or unexpected acknowledge on the ninth clock. A bad pointer is visible in the read-back data, or in a `reg_we` pulse at the wrong index. A bad end-of-range state is visible in the bytes that follow the highest register: a read that wraps to a low register, or a write that is stored or acknowledged. A failure to abort on start or stop is visible as a stray stored byte, or as a lost acknowledge on the next transfer.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h28,
  parameter int NREGS = 16,
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          addr_strap,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WDAT, S_WACK, S_RDAT, S_RACK
  } st_t;

  localparam logic [AW-1:0] LAST = AW'(NREGS - 1);

  st_t           state;
  logic [2:0]    scl_q, sda_q;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [AW-1:0] ptr;
  logic          over, rw;

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];

  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_done = scl_fall && (bitcnt == 4'd8);
  wire rx_state  = (state == S_ADDR) || (state == S_SUB) || (state == S_WDAT);

  wire [6:0] my_addr  = {DEV_ADDR[6:2], addr_strap, DEV_ADDR[0]};
  wire       addr_hit = (shreg[7:1] == my_addr);
  wire       sub_ok   = !shreg[7] && ({1'b0, shreg[6:0]} < 8'(NREGS));

  assign reg_we    = (state == S_WDAT) && byte_done && !over;
  assign reg_addr  = ptr;
  assign reg_wdata = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 3'b111;
      sda_q  <= 3'b111;
      state  <= S_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      ptr    <= '0;
      over   <= 1'b0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (rx_state && scl_rise && bitcnt != 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
        case (state)
          S_ADDR: if (byte_done) begin
            if (addr_hit) begin
              rw     <= shreg[0];
              sda_oe <= 1'b1;
              state  <= S_AACK;
            end else begin
              state  <= S_IDLE;
            end
          end
          S_SUB: if (byte_done) begin
            if (sub_ok) begin
              ptr    <= shreg[AW-1:0];
              over   <= 1'b0;
              sda_oe <= 1'b1;
              state  <= S_SACK;
            end else begin
              state  <= S_IDLE;
            end
          end
          S_WDAT: if (byte_done) begin
            if (!over) begin
              if (ptr == LAST) over <= 1'b1;
              else             ptr  <= ptr + 1'b1;
              sda_oe <= 1'b1;
              state  <= S_WACK;
            end else begin
              state  <= S_IDLE;
            end
          end
          S_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              shreg  <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= S_RDAT;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_SUB;
            end
          end
          S_SACK, S_WACK: if (scl_fall) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
            state  <= S_WDAT;
          end
          S_RDAT: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              if (ptr == LAST) over <= 1'b1;
              else             ptr  <= ptr + 1'b1;
              state  <= S_RACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise && sda_s) begin
              state <= S_IDLE;
            end else if (scl_fall) begin
              bitcnt <= '0;
              shreg  <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              state  <= S_RDAT;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module cfg_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_we
);
  // R7
  sda_grab_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  // R3
  sda_free_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);
  // R5
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R5
  we_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !scl_i && !sda_oe);
  // R3
  ack_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> sda_oe);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .reg_we(reg_we)
);

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;
  localparam int NREGS = 16;
  localparam int AW = 4;
  localparam int Q = 8;
  localparam logic [6:0] A0 = 7'h28;
  localparam logic [6:0] A1 = 7'h2A;
  localparam logic [11:0] VEC [0:5] = '{
    {4'h0, 8'hA5}, {4'h3, 8'h5A}, {4'h7, 8'hFF},
    {4'h9, 8'h01}, {4'hC, 8'h80}, {4'hF, 8'h3C}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic strap = 1'b0;
  logic sda_oe, reg_we;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] rf [0:NREGS-1];
  logic [7:0] ex [0:NREGS-1];
  int checks = 0, fails = 0;
  bit done = 0;

  wire sda = !(m_low || sda_oe);

  always #2 clk = ~clk;

  cfg_i2c_slave #(.DEV_ADDR(A0), .NREGS(NREGS)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .addr_strap(strap), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < NREGS; i++) rf[i] <= 8'h00;
    else if (reg_we) rf[reg_addr] <= reg_wdata;
  assign reg_rdata = rf[reg_addr];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart; m_low = 0; w(Q); scl = 1; w(Q); m_low = 1; w(Q); scl = 0; w(Q); endtask
  task automatic bstop; m_low = 1; w(Q); scl = 1; w(Q); m_low = 0; w(2*Q); endtask
  task automatic bout(input logic b); m_low = !b; w(Q); scl = 1; w(2*Q); scl = 0; w(Q); endtask
  task automatic bin(output logic b); m_low = 0; w(Q); scl = 1; w(Q); b = sda; w(Q); scl = 0; w(Q); endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bout(d[i]);
    bin(a);
    ack = !a;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bin(d[i]);
    bout(!give_ack);
  endtask

  task automatic wr1(input logic [6:0] dev, input logic [7:0] sub, input logic [7:0] d,
                     output logic [2:0] acks);
    bstart; wbyte({dev, 1'b0}, acks[0]); wbyte(sub, acks[1]); wbyte(d, acks[2]); bstop;
  endtask

  task automatic rd1(input logic [6:0] dev, input logic [7:0] sub, output logic [7:0] d);
    logic a;
    bstart; wbyte({dev, 1'b0}, a); wbyte(sub, a);
    bstart; wbyte({dev, 1'b1}, a); rbyte(1'b0, d); bstop;
  endtask

  initial begin
    logic [2:0] ak;
    logic a;
    logic [7:0] d;
    w(5);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 reg_we", reg_we, 0);
    rst_n = 1;
    w(5);
    chk("R1 sda_oe after release", sda_oe, 0);
    for (int i = 0; i < NREGS; i++) ex[i] = 8'h00;

    for (int v = 0; v < 6; v++) begin
      wr1(A0, {4'h0, VEC[v][11:8]}, VEC[v][7:0], ak);
      ex[VEC[v][11:8]] = VEC[v][7:0];
      chk("R3 write acks", ak, 3'b111);
      chk("R5 stored", rf[VEC[v][11:8]], VEC[v][7:0]);
      rd1(A0, {4'h0, VEC[v][11:8]}, d);
      chk("R7 R10 readback", d, VEC[v][7:0]);
    end

    wr1(A1, 8'h01, 8'h77, ak);
    chk("R2 wrong strap nack", ak, 3'b000);
    chk("R2 nothing stored", rf[1], ex[1]);
    strap = 1;
    wr1(A1, 8'h01, 8'h77, ak); ex[1] = 8'h77;
    chk("R2 strap address acks", ak, 3'b111);
    chk("R2 strap stored", rf[1], 8'h77);
    wr1(A0, 8'h02, 8'h11, ak);
    chk("R2 old address refused", ak, 3'b000);
    strap = 0;

    wr1(A0, 8'h82, 8'h44, ak);
    chk("R4 bit7 sub nack", ak, 3'b001);
    chk("R4 bit7 not stored", rf[2], ex[2]);
    wr1(A0, 8'h10, 8'h44, ak);
    chk("R4 out of range sub nack", ak, 3'b001);
    chk("R4 reg0 untouched", rf[0], ex[0]);

    bstart; wbyte({A0, 1'b0}, a); wbyte(8'h04, a);
    for (int i = 0; i < 4; i++) begin
      wbyte(8'h20 + 8'(i), a);
      chk("R5 burst ack", a, 1);
      ex[4+i] = 8'h20 + 8'(i);
    end
    bstop;
    bstart; wbyte({A0, 1'b0}, a); wbyte(8'h04, a);
    bstart; wbyte({A0, 1'b1}, a);
    for (int i = 0; i < 4; i++) begin
      rbyte(i != 3, d);
      chk("R7 burst read", d, ex[4+i]);
    end
    bstop;
    chk("R8 released after nack", sda_oe, 0);

    bstart; wbyte({A0, 1'b0}, a); wbyte(8'h0E, a);
    wbyte(8'hE1, a); chk("R6 ack at 14", a, 1);
    wbyte(8'hF2, a); chk("R6 ack at 15", a, 1);
    wbyte(8'hD3, a); chk("R6 nack past end", a, 0);
    wbyte(8'hC4, a); chk("R6 idle after past end", a, 0);
    bstop;
    ex[14] = 8'hE1; ex[15] = 8'hF2;
    chk("R6 last holds", rf[15], 8'hF2);
    chk("R6 no wrap", rf[0], ex[0]);

    bstart; wbyte({A0, 1'b0}, a); wbyte(8'h0E, a);
    bstart; wbyte({A0, 1'b1}, a);
    rbyte(1, d); chk("R8 read 14", d, 8'hE1);
    rbyte(1, d); chk("R8 read 15", d, 8'hF2);
    rbyte(1, d); chk("R8 repeat 15", d, 8'hF2);
    rbyte(0, d); chk("R8 repeat 15 again", d, 8'hF2);
    bstop;
    chk("R8 sda free", sda_oe, 0);

    bstart; wbyte({A0, 1'b0}, a); wbyte(8'h05, a);
    bout(1); bout(1); bout(0); bout(1);
    bstop;
    chk("R9 partial byte not stored", rf[5], ex[5]);
    bstart; wbyte({A0, 1'b0}, a); wbyte(8'h06, a);
    bout(0); bout(1); bout(1);
    bstart; wbyte({A0, 1'b1}, a);
    chk("R9 start aborts and readdresses", a, 1);
    rbyte(0, d); bstop;
    chk("R9 R10 read at kept pointer", d, ex[6]);
    chk("R9 reg6 unchanged", rf[6], ex[6]);
    wr1(A0, 8'h09, 8'h99, ak);
    chk("R9 next transfer acks", ak, 3'b111);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule